// File: doc/BRIEF.md
# Configuration Header Register Bank

This block is the register bank behind the 64-byte type-0 configuration header of a simple bus target. The bus front end latches the command code and the low byte of the address during the address phase. It then presents these, together with the 32-bit data bus, the active-low byte enables and the two active-low ready handshakes, to this bank for every data phase. The bank turns configuration reads into read data. It turns completed configuration writes into updates of its three writable registers: the command register, the first base address register and the interrupt line.

Everything else in the header is a read-only constant chosen by parameters: the vendor, device and subsystem identities, the revision and class, the header type, the timers and the interrupt routing fields. Reserved words and the device-specific region above the header read as zero. Writes to any offset other than the three writable words are dropped. The current contents of the three writable registers are also brought out as ports, so the surrounding target logic can use the enables, the decode base and the routing value.

Top module: `pci_cfg_hdr_bank`

## Requirements
- R1: An active-low asynchronous reset clears the command register, the base address register and the interrupt line to zero without waiting for a clock edge.
- R2: `rd_data` shows header contents only while `cfg_cmd` equals 4'b1010 (configuration read). With any other command code, 4'b1011 included, it is zero.
- R3: Reading offset 00h returns {DEV_ID, VEN_ID}. Offset 08h returns {CLASS_CODE, REV_ID}. Offset 0Ch returns {BIST_VAL, HDR_TYPE, LAT_TIMER, CACHE_LINE}. Offset 2Ch returns {SUBSYS_ID, SUBSYS_VEN_ID}. In each case the first field named is the most significant.
- R4: A register is written only on a rising clock edge where `cfg_cmd` equals 4'b1011, `irdy_n` is 0 and `trdy_n` is 0. If either handshake is high, or any other command is present, nothing changes.
- R5: Byte enables are active low. A 0 in `be_n[n]` lets `ad_in[8n+7:8n]` update that byte. A 1 leaves the byte unchanged.
- R6: At offset 04h, bits [CMD_WBITS-1:0] of the command register are writable and reset to 0, and the remaining bits of the low half read as 0. Bits [31:16] read as the constant STATUS_VAL.
- R7: At offset 10h, bits [31:BAR_SIZE_LOG2] of the base address register are writable, and bits [BAR_SIZE_LOG2-1:0] always read as 0. The default is a 4 KB window.
- R8: At offset 3Ch, only bits [7:0] (the interrupt line) are writable. The word reads {MAX_LAT, MIN_GNT, INT_PIN, interrupt line}, with MAX_LAT as the most significant byte.
- R9: A configuration write to any offset other than exactly 04h, 10h or 3Ch is discarded. This covers the identity words, offsets that are not dword-aligned and 40h–FFh.
- R10: Offsets 14h–28h, 30h, 34h, 38h, every offset that is not dword-aligned, and 40h–FFh all read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cmd | input | 4 | Command code latched during the address phase |
| cfg_off | input | 8 | Byte offset into configuration space, latched during the address phase |
| ad_in | input | 32 | Write data from the address/data bus |
| be_n | input | 4 | Byte enables for the data phase, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| rd_data | output | 32 | Configuration read data, zero outside a configuration read |
| cmd_o | output | 16 | Current command register contents |
| bar_o | output | 32 | Current base address register contents |
| int_line_o | output | 8 | Current interrupt line value |

## Verification
The hardest situation to reach from the ports is a write that is almost complete: the right command and a writable offset with the byte enables active, but only one of the two handshakes low. Close behind it is a partial-lane write whose enabled lanes fall entirely on read-only bits. Directed steps build each of these cases explicitly. Random stimulus then draws the handshakes independently, so single-low cases keep recurring. It also biases offsets toward the three writable words plus unaligned and high neighbours, and draws byte-enable patterns freely. Every step reads the affected word back through the read path and compares it with a bench model.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

   localparam logic [3:0] CMD_CFG_RD = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR = 4'b1011;

   localparam logic [7:0] OFF_IDENT  = 8'h00;
   localparam logic [7:0] OFF_CTRL   = 8'h04;
   localparam logic [7:0] OFF_CLASS  = 8'h08;
   localparam logic [7:0] OFF_MISC   = 8'h0C;
   localparam logic [7:0] OFF_BASE0  = 8'h10;
   localparam logic [7:0] OFF_SUBSYS = 8'h2C;
   localparam logic [7:0] OFF_IRQ    = 8'h3C;

   localparam int LANE_W = 8;

   // write strobes produced by the cycle decoder
   typedef struct packed {
      logic ctrl;
      logic base;
      logic irq;
   } cfg_wr_t;

   function automatic logic [31:0] low_ones(input int n);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++)
         if (i < n) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cfg_cycle_decode.sv
module cfg_cycle_decode
   import pci_cfg_pkg::*;
(
   input  logic [3:0] cfg_cmd,
   input  logic [7:0] cfg_off,
   input  logic       irdy_n,
   input  logic       trdy_n,
   output logic       rd_act,
   output cfg_wr_t    wr_stb
);

   logic xfer_done;

   assign rd_act    = (cfg_cmd == CMD_CFG_RD);
   assign xfer_done = (cfg_cmd == CMD_CFG_WR) && !irdy_n && !trdy_n;

   always_comb begin
      wr_stb = '0;
      if (xfer_done) begin
         unique case (cfg_off)
            OFF_CTRL:  wr_stb.ctrl = 1'b1;
            OFF_BASE0: wr_stb.base = 1'b1;
            OFF_IRQ:   wr_stb.irq  = 1'b1;
            default:   wr_stb = '0;
         endcase
      end
   end

endmodule

// File: rtl/cfg_lane_reg.sv
module cfg_lane_reg
   import pci_cfg_pkg::*;
#(
   parameter int                      LANES = 4,
   parameter logic [LANES*LANE_W-1:0] WMASK = '1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [LANES-1:0]          be_n,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   q
);

   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("cfg_lane_reg: LANES must lie in 1..4");
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam logic [LANE_W-1:0] LMASK = WMASK[ln*LANE_W +: LANE_W];
      if (LMASK == '0) begin : g_const
         assign q[ln*LANE_W +: LANE_W] = '0;
      end else begin : g_flop
         logic [LANE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (wr_en && !be_n[ln])
               lane_q <= wdata[ln*LANE_W +: LANE_W] & LMASK;
         end
         assign q[ln*LANE_W +: LANE_W] = lane_q;
      end
   end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import pci_cfg_pkg::*;
#(
   parameter logic [15:0] VEN_ID        = 16'h0,
   parameter logic [15:0] DEV_ID        = 16'h0,
   parameter logic [7:0]  REV_ID        = 8'h0,
   parameter logic [23:0] CLASS_CODE    = 24'h0,
   parameter logic [7:0]  CACHE_LINE    = 8'h0,
   parameter logic [7:0]  LAT_TIMER     = 8'h0,
   parameter logic [7:0]  HDR_TYPE      = 8'h0,
   parameter logic [7:0]  BIST_VAL      = 8'h0,
   parameter logic [15:0] SUBSYS_VEN_ID = 16'h0,
   parameter logic [15:0] SUBSYS_ID     = 16'h0,
   parameter logic [15:0] STATUS_VAL    = 16'h0,
   parameter logic [7:0]  INT_PIN       = 8'h0,
   parameter logic [7:0]  MIN_GNT       = 8'h0,
   parameter logic [7:0]  MAX_LAT       = 8'h0
)(
   input  logic        rd_act,
   input  logic [7:0]  cfg_off,
   input  logic [15:0] ctrl_q,
   input  logic [31:0] base_q,
   input  logic [7:0]  irq_q,
   output logic [31:0] rd_data
);

   logic [31:0] word;

   always_comb begin
      unique case (cfg_off)
         OFF_IDENT:  word = {DEV_ID, VEN_ID};
         OFF_CTRL:   word = {STATUS_VAL, ctrl_q};
         OFF_CLASS:  word = {CLASS_CODE, REV_ID};
         OFF_MISC:   word = {BIST_VAL, HDR_TYPE, LAT_TIMER, CACHE_LINE};
         OFF_BASE0:  word = base_q;
         OFF_SUBSYS: word = {SUBSYS_ID, SUBSYS_VEN_ID};
         OFF_IRQ:    word = {MAX_LAT, MIN_GNT, INT_PIN, irq_q};
         default:    word = '0;
      endcase
   end

   assign rd_data = rd_act ? word : '0;

endmodule

// File: rtl/pci_cfg_hdr_bank.sv
module pci_cfg_hdr_bank
   import pci_cfg_pkg::*;
#(
   parameter logic [15:0] VEN_ID        = 16'hA55A,
   parameter logic [15:0] DEV_ID        = 16'h3C01,
   parameter logic [7:0]  REV_ID        = 8'h01,
   parameter logic [23:0] CLASS_CODE    = 24'h118000,
   parameter logic [7:0]  CACHE_LINE    = 8'h00,
   parameter logic [7:0]  LAT_TIMER     = 8'h00,
   parameter logic [7:0]  HDR_TYPE      = 8'h00,
   parameter logic [7:0]  BIST_VAL      = 8'h00,
   parameter logic [15:0] SUBSYS_VEN_ID = 16'h0000,
   parameter logic [15:0] SUBSYS_ID     = 16'h0000,
   parameter logic [15:0] STATUS_VAL    = 16'h0200,
   parameter logic [7:0]  INT_PIN       = 8'h01,
   parameter logic [7:0]  MIN_GNT       = 8'h00,
   parameter logic [7:0]  MAX_LAT       = 8'h00,
   parameter int          CMD_WBITS     = 11,
   parameter int          BAR_SIZE_LOG2 = 12
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  cfg_cmd,
   input  logic [7:0]  cfg_off,
   input  logic [31:0] ad_in,
   input  logic [3:0]  be_n,
   input  logic        irdy_n,
   input  logic        trdy_n,
   output logic [31:0] rd_data,
   output logic [15:0] cmd_o,
   output logic [31:0] bar_o,
   output logic [7:0]  int_line_o
);

   localparam logic [15:0] CTRL_MASK = 16'(low_ones(CMD_WBITS));
   localparam logic [31:0] BASE_MASK = ~low_ones(BAR_SIZE_LOG2);
   localparam logic [7:0]  IRQ_MASK  = 8'hFF;

   if (CMD_WBITS < 1 || CMD_WBITS > 16) begin : g_bad_cmd
      $error("pci_cfg_hdr_bank: CMD_WBITS must lie in 1..16");
   end
   if (BAR_SIZE_LOG2 < 4 || BAR_SIZE_LOG2 > 31) begin : g_bad_bar
      $error("pci_cfg_hdr_bank: BAR_SIZE_LOG2 must lie in 4..31");
   end

   logic    rd_act;
   cfg_wr_t wr_stb;

   cfg_cycle_decode i_dec (
      .cfg_cmd (cfg_cmd),
      .cfg_off (cfg_off),
      .irdy_n  (irdy_n),
      .trdy_n  (trdy_n),
      .rd_act  (rd_act),
      .wr_stb  (wr_stb)
   );

   cfg_lane_reg #(.LANES(2), .WMASK(CTRL_MASK)) i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_stb.ctrl),
      .be_n  (be_n[1:0]),
      .wdata (ad_in[15:0]),
      .q     (cmd_o)
   );

   cfg_lane_reg #(.LANES(4), .WMASK(BASE_MASK)) i_base (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_stb.base),
      .be_n  (be_n),
      .wdata (ad_in),
      .q     (bar_o)
   );

   cfg_lane_reg #(.LANES(1), .WMASK(IRQ_MASK)) i_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_stb.irq),
      .be_n  (be_n[0]),
      .wdata (ad_in[7:0]),
      .q     (int_line_o)
   );

   cfg_read_mux #(
      .VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .REV_ID(REV_ID), .CLASS_CODE(CLASS_CODE),
      .CACHE_LINE(CACHE_LINE), .LAT_TIMER(LAT_TIMER), .HDR_TYPE(HDR_TYPE),
      .BIST_VAL(BIST_VAL), .SUBSYS_VEN_ID(SUBSYS_VEN_ID), .SUBSYS_ID(SUBSYS_ID),
      .STATUS_VAL(STATUS_VAL), .INT_PIN(INT_PIN), .MIN_GNT(MIN_GNT), .MAX_LAT(MAX_LAT)
   ) i_rmux (
      .rd_act  (rd_act),
      .cfg_off (cfg_off),
      .ctrl_q  (cmd_o),
      .base_q  (bar_o),
      .irq_q   (int_line_o),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/pci_cfg_hdr_chk.sv
module pci_cfg_hdr_chk #(
   parameter logic [15:0] VEN_ID        = 16'h0,
   parameter logic [15:0] DEV_ID        = 16'h0,
   parameter int          BAR_SIZE_LOG2 = 12
)(
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  cfg_cmd,
   input logic [7:0]  cfg_off,
   input logic [3:0]  be_n,
   input logic        irdy_n,
   input logic        trdy_n,
   input logic [31:0] rd_data,
   input logic [15:0] cmd_o,
   input logic [31:0] bar_o,
   input logic [7:0]  int_line_o
);

   logic done_wr;
   assign done_wr = (cfg_cmd == 4'b1011) && !irdy_n && !trdy_n;

   // R2
   rd_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cmd != 4'b1010) |-> (rd_data == 32'h0));

   // R3
   ident_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cmd == 4'b1010 && cfg_off == 8'h00) |-> (rd_data == {DEV_ID, VEN_ID}));

   // R10
   high_region_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cmd == 4'b1010 && cfg_off >= 8'h40) |-> (rd_data == 32'h0));

   // R4
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_wr && cfg_off == 8'h04) |=> $stable(cmd_o));

   // R9
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_wr && cfg_off == 8'h10) |=> $stable(bar_o));

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_wr && cfg_off == 8'h3C && !be_n[0]) |=> $stable(int_line_o));

   // R7
   base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_o[BAR_SIZE_LOG2-1:0] == '0));

   // R5
   ctrl_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (be_n[1:0] == 2'b11) |=> $stable(cmd_o));

endmodule

bind pci_cfg_hdr_bank pci_cfg_hdr_chk #(
   .VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
) i_pci_cfg_hdr_chk (
   .clk(clk), .rst_n(rst_n), .cfg_cmd(cfg_cmd), .cfg_off(cfg_off), .be_n(be_n),
   .irdy_n(irdy_n), .trdy_n(trdy_n), .rd_data(rd_data), .cmd_o(cmd_o),
   .bar_o(bar_o), .int_line_o(int_line_o)
);

// File: tb/test_pci_cfg_hdr_bank.sv
module test_pci_cfg_hdr_bank;

   localparam logic [15:0] T_VEN   = 16'hA55A;
   localparam logic [15:0] T_DEV   = 16'h3C01;
   localparam logic [7:0]  T_REV   = 8'h07;
   localparam logic [23:0] T_CLASS = 24'h118000;
   localparam logic [7:0]  T_CLS   = 8'h08;
   localparam logic [7:0]  T_LAT   = 8'h20;
   localparam logic [7:0]  T_HDR   = 8'h00;
   localparam logic [7:0]  T_BIST  = 8'h00;
   localparam logic [15:0] T_SVEN  = 16'h5AA5;
   localparam logic [15:0] T_SID   = 16'h0042;
   localparam logic [15:0] T_STAT  = 16'h0200;
   localparam logic [7:0]  T_PIN   = 8'h01;
   localparam logic [7:0]  T_MING  = 8'h04;
   localparam logic [7:0]  T_MAXL  = 8'h10;
   localparam logic [15:0] M_CMD   = 16'h07FF;
   localparam logic [31:0] M_BAR   = 32'hFFFFF000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_cmd = 4'h0;
   logic [7:0]  cfg_off = 8'h0;
   logic [31:0] ad_in = 32'h0;
   logic [3:0]  be_n = 4'hF;
   logic        irdy_n = 1'b1;
   logic        trdy_n = 1'b1;
   logic [31:0] rd_data;
   logic [15:0] cmd_o;
   logic [31:0] bar_o;
   logic [7:0]  int_line_o;

   int checks = 0;
   int failures = 0;

   logic [15:0] m_cmd = '0;
   logic [31:0] m_bar = '0;
   logic [7:0]  m_il  = '0;

   always #10 clk = ~clk;

   pci_cfg_hdr_bank #(
      .VEN_ID(T_VEN), .DEV_ID(T_DEV), .REV_ID(T_REV), .CLASS_CODE(T_CLASS),
      .CACHE_LINE(T_CLS), .LAT_TIMER(T_LAT), .HDR_TYPE(T_HDR), .BIST_VAL(T_BIST),
      .SUBSYS_VEN_ID(T_SVEN), .SUBSYS_ID(T_SID), .STATUS_VAL(T_STAT),
      .INT_PIN(T_PIN), .MIN_GNT(T_MING), .MAX_LAT(T_MAXL),
      .CMD_WBITS(11), .BAR_SIZE_LOG2(12)
   ) i_pci_cfg_hdr_bank (
      .clk(clk), .rst_n(rst_n), .cfg_cmd(cfg_cmd), .cfg_off(cfg_off), .ad_in(ad_in),
      .be_n(be_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .rd_data(rd_data),
      .cmd_o(cmd_o), .bar_o(bar_o), .int_line_o(int_line_o)
   );

   function automatic logic [31:0] exp_word(input logic [7:0] off);
      case (off)
         8'h00:   return {T_DEV, T_VEN};
         8'h04:   return {T_STAT, m_cmd};
         8'h08:   return {T_CLASS, T_REV};
         8'h0C:   return {T_BIST, T_HDR, T_LAT, T_CLS};
         8'h10:   return m_bar;
         8'h2C:   return {T_SID, T_SVEN};
         8'h3C:   return {T_MAXL, T_MING, T_PIN, m_il};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                         input logic [3:0] ben, input logic [31:0] msk);
      logic [31:0] r;
      r = old;
      for (int i = 0; i < 4; i++)
         if (!ben[i]) r[i*8 +: 8] = d[i*8 +: 8] & msk[i*8 +: 8];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one data phase; the model follows the requirement rules
   task automatic phase(input logic [3:0] c, input logic [7:0] o, input logic [31:0] d,
                        input logic [3:0] b, input logic ir, input logic tr);
      @(negedge clk);
      cfg_cmd = c; cfg_off = o; ad_in = d; be_n = b; irdy_n = ir; trdy_n = tr;
      if (c == 4'b1011 && !ir && !tr) begin
         if (o == 8'h04) m_cmd = merge({16'h0, m_cmd}, d, {2'b11, b[1:0]}, {16'h0, M_CMD})[15:0];
         if (o == 8'h10) m_bar = merge(m_bar, d, b, M_BAR);
         if (o == 8'h3C) m_il  = merge({24'h0, m_il}, d, {3'b111, b[0]}, 32'hFF)[7:0];
      end
      @(posedge clk);
   endtask

   task automatic rd(input string req, input logic [7:0] o);
      @(negedge clk);
      cfg_cmd = 4'b1010; cfg_off = o; irdy_n = 1'b1; trdy_n = 1'b1; be_n = 4'hF;
      #5;
      chk(req, rd_data, exp_word(o));
      chk(req, {cmd_o, int_line_o, 8'h0}, {m_cmd, m_il, 8'h0});
      chk(req, bar_o, m_bar);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] picks [7];
      picks = '{8'h04, 8'h10, 8'h3C, 8'h00, 8'h08, 8'h40, 8'h05};
      void'($urandom(32'd20240611));

      // R1 reset state
      #35;
      chk("R1", {cmd_o, int_line_o, 8'h0}, 32'h0);
      chk("R1", bar_o, 32'h0);
      chk("R2", rd_data, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R3 identity words
      rd("R3", 8'h00); rd("R3", 8'h08); rd("R3", 8'h0C); rd("R3", 8'h2C);
      // R10 zero words
      rd("R10", 8'h34); rd("R10", 8'h38); rd("R10", 8'h40); rd("R10", 8'hFC);
      rd("R10", 8'h14); rd("R10", 8'h30); rd("R10", 8'h01);

      // R6 command register
      phase(4'b1011, 8'h04, 32'hFFFF_FFFF, 4'b0000, 1'b0, 1'b0);
      rd("R6", 8'h04);
      chk("R6", {16'h0, cmd_o}, 32'h0000_07FF);
      // R7 base address register
      phase(4'b1011, 8'h10, 32'hFFFF_FFFF, 4'b0000, 1'b0, 1'b0);
      rd("R7", 8'h10);
      chk("R7", bar_o, 32'hFFFF_F000);
      // R8 interrupt word
      phase(4'b1011, 8'h3C, 32'hFFFF_FFAB, 4'b0000, 1'b0, 1'b0);
      rd("R8", 8'h3C);
      chk("R8", {24'h0, int_line_o}, 32'h0000_00AB);

      // R4 incomplete handshakes and wrong commands
      phase(4'b1011, 8'h10, 32'h1234_5000, 4'b0000, 1'b1, 1'b0);
      rd("R4", 8'h10);
      phase(4'b1011, 8'h10, 32'h1234_5000, 4'b0000, 1'b0, 1'b1);
      rd("R4", 8'h10);
      phase(4'b1010, 8'h10, 32'h1234_5000, 4'b0000, 1'b0, 1'b0);
      rd("R4", 8'h10);
      phase(4'b0111, 8'h04, 32'h0, 4'b0000, 1'b0, 1'b0);
      rd("R4", 8'h04);
      chk("R4", bar_o, 32'hFFFF_F000);

      // R5 single lanes
      phase(4'b1011, 8'h10, 32'h5600_0000, 4'b0111, 1'b0, 1'b0);
      rd("R5", 8'h10);
      chk("R5", bar_o, 32'h56FF_F000);
      phase(4'b1011, 8'h10, 32'h0000_0000, 4'b1110, 1'b0, 1'b0);
      rd("R5", 8'h10);
      phase(4'b1011, 8'h04, 32'h0000_0000, 4'b1101, 1'b0, 1'b0);
      rd("R5", 8'h04);
      chk("R5", {16'h0, cmd_o}, 32'h0000_00FF);

      // R9 discarded writes
      phase(4'b1011, 8'h00, 32'h0, 4'b0000, 1'b0, 1'b0);
      rd("R9", 8'h00);
      phase(4'b1011, 8'h40, 32'h0, 4'b0000, 1'b0, 1'b0);
      rd("R9", 8'h40);
      phase(4'b1011, 8'h11, 32'h0, 4'b0000, 1'b0, 1'b0);
      rd("R9", 8'h10);
      phase(4'b1011, 8'h3D, 32'h0, 4'b0000, 1'b0, 1'b0);
      rd("R9", 8'h3C);

      // R2 write command presents no read data
      @(negedge clk); cfg_cmd = 4'b1011; cfg_off = 8'h00; irdy_n = 1'b1; #5;
      chk("R2", rd_data, 32'h0);

      // random mix, every requirement through the model
      for (int n = 0; n < 600; n++) begin
         logic [3:0] c;
         logic [7:0] o;
         int sel;
         sel = $urandom % 4;
         c = (sel < 2) ? 4'b1011 : (sel == 2) ? 4'b1010 : 4'($urandom);
         o = ($urandom % 3 == 0) ? 8'($urandom) : picks[$urandom % 7];
         phase(c, o, $urandom, 4'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 3 == 0));
         rd("R4", picks[$urandom % 3]);
      end

      // R1 asynchronous reset mid-run
      @(negedge clk); #3 rst_n = 1'b0; #2;
      chk("R1", {cmd_o, int_line_o, 8'h0}, 32'h0);
      chk("R1", bar_o, 32'h0);
      m_cmd = '0; m_bar = '0; m_il = '0;
      @(negedge clk); rst_n = 1'b1;
      rd("R1", 8'h10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule